// File: doc/BRIEF.md
# Periodic Compare Timer with Request Pulse

This block is a 16-bit up-counting timer that divides its clock by 4, 8, 16 or 64, compares its count against a programmable limit and wraps to zero each time the two agree. Every wrap sets a sticky status flag and raises a one-clock request pulse. A DMA engine can use that pulse as a periodic transfer trigger, and software can poll the flag.

Software reaches four registers over a simple single-cycle register bus. Reads are combinational on `bus_rdata`. A write takes effect at the next clock edge. The start bit runs or halts the timer. The status register holds the flag and the divider select. The count register can be loaded at any time, and the limit register sets the period.

Two state machines run the block. The run machine has states RUN_IDLE and RUN_ACTIVE:
- RUN_IDLE goes to RUN_ACTIVE on a start write with bit 0 = 1.
- RUN_ACTIVE goes to RUN_IDLE on a start write with bit 0 = 0.

The flag machine has states FLAG_LOW, FLAG_HIGH and FLAG_ARMED:
- Any state goes to FLAG_HIGH on a wrap. This transition has priority over all others.
- FLAG_HIGH goes to FLAG_ARMED when the status register is read.
- FLAG_ARMED goes to FLAG_LOW on a status write with bit 7 = 0.
- FLAG_ARMED goes back to FLAG_HIGH on a status write with bit 7 = 1.

Top module: `match_timer`

## Requirements
- R1: After reset the count is 0, the limit is 0xFFFF, the timer is halted, the flag is clear, the divider select is 00 and `dma_req` is low.
- R2: Writing 1 to bit 0 of the start register runs the timer, and writing 0 halts it. A read of the start register returns the run state in bit 0.
- R3: While running, the count advances once every 4, 8, 16 or 64 clocks for divider select 00, 01, 10 or 11. The first advance comes a full division period after the start write takes effect.
- R4: On an advance while the count equals the limit, the count becomes 0 and the flag sets. The period is therefore (limit+1) x division clocks.
- R5: The flag clears only on a status write with bit 7 = 0 that follows a read of the status register showing the flag at 1. A write without that read, or a write with bit 7 = 1, leaves the flag set.
- R6: While halted, the count holds its value except when software writes it, and no request pulse appears.
- R7: A write to the count register loads the written value at the next edge. The load wins over an advance at the same edge.
- R8: Each wrap gives exactly one `dma_req` pulse of one clock, in the clock that follows the wrap edge.
- R9: Halting the timer resets the divider phase, so a restart waits a full division period again.
- R10: The register map is: address 0 is start (bit 0); address 1 is status (bit 7 flag, bits 1:0 divider select); address 2 is count; address 3 is limit. Unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |
| dma_req | output | 1 | One-clock request pulse per wrap |

## Verification
The bench builds the block with the default 16-bit counter, so the divider widths and the 0xFFFF reset limit are exactly those stated in the requirements. Before the periodic test, the bench programs the limit down to 2. A divide-by-4 period then lasts twelve clocks, and ten wraps fit in a window of about 120 clocks, where the pulse count shows both the period and the pulse width. Each divider setting is checked after exactly three counts, which keeps even the divide-by-64 case under 200 clocks.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_CSR   = 2'd1,
        REG_COUNT = 2'd2,
        REG_LIMIT = 2'd3
    } reg_sel_t;

    typedef enum logic {
        RUN_IDLE,
        RUN_ACTIVE
    } run_state_t;

    typedef enum logic [1:0] {
        FLAG_LOW,
        FLAG_HIGH,
        FLAG_ARMED
    } flag_state_t;

    localparam int CSR_FLAG_BIT = 7;
    localparam int MAX_SHIFT    = 6;

    // log2 of the clock division for each select code
    function automatic int div_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2;
            2'b01:   return 3;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
    import mt_pkg::*;
#(
    parameter int PRE_W = MAX_SHIFT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = PRE_W'((1 << div_shift(sel)) - 1);
        tick  = run && (phase_q >= limit);
    end

    // the phase returns to 0 when halted, so a restart waits a full period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    logic at_limit;

    always_comb begin
        at_limit = (count == limit);
        wrap     = tick && at_limit && !load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= at_limit ? '0 : count + 1'b1;
        end
    end

endmodule

// File: rtl/mt_flag_fsm.sv
module mt_flag_fsm
    import mt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic csr_rd,
    input  logic csr_wr,
    input  logic wr_flag_bit,
    output logic flag
);

    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (set) begin
            state_d = FLAG_HIGH;
        end else begin
            unique case (state_q)
                FLAG_LOW:   state_d = FLAG_LOW;
                FLAG_HIGH:  if (csr_rd) state_d = FLAG_ARMED;
                FLAG_ARMED: if (csr_wr) state_d = wr_flag_bit ? FLAG_HIGH : FLAG_LOW;
                default:    state_d = FLAG_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q != FLAG_LOW);
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             dma_req
);

    localparam int PRE_W = MAX_SHIFT;

    reg_sel_t   reg_sel;
    logic       wr_start, wr_csr, wr_count, wr_limit, rd_csr;
    run_state_t run_q, run_d;
    logic       run_on;
    logic [1:0] sel_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] cnt_q;
    logic       pre_tick;
    logic       wrap;
    logic       flag_on;

    always_comb begin
        reg_sel  = reg_sel_t'(bus_addr);
        wr_start = bus_en && bus_we && (reg_sel == REG_START);
        wr_csr   = bus_en && bus_we && (reg_sel == REG_CSR);
        wr_count = bus_en && bus_we && (reg_sel == REG_COUNT);
        wr_limit = bus_en && bus_we && (reg_sel == REG_LIMIT);
        rd_csr   = bus_en && !bus_we && (reg_sel == REG_CSR);
    end

    // run state machine
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_IDLE:   if (wr_start &&  bus_wdata[0]) run_d = RUN_ACTIVE;
            RUN_ACTIVE: if (wr_start && !bus_wdata[0]) run_d = RUN_IDLE;
            default:    run_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= RUN_IDLE;
        else        run_q <= run_d;
    end

    always_comb begin
        run_on = (run_q == RUN_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 2'b00;
            limit_q <= '1;
            dma_req <= 1'b0;
        end else begin
            if (wr_csr)   sel_q   <= bus_wdata[1:0];
            if (wr_limit) limit_q <= bus_wdata;
            dma_req <= wrap;
        end
    end

    mt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_on),
        .sel   (sel_q),
        .tick  (pre_tick)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (pre_tick),
        .load     (wr_count),
        .load_val (bus_wdata),
        .limit    (limit_q),
        .count    (cnt_q),
        .wrap     (wrap)
    );

    mt_flag_fsm u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (wrap),
        .csr_rd      (rd_csr),
        .csr_wr      (wr_csr),
        .wr_flag_bit (bus_wdata[CSR_FLAG_BIT]),
        .flag        (flag_on)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_START: bus_rdata[0] = run_on;
            REG_CSR: begin
                bus_rdata[CSR_FLAG_BIT] = flag_on;
                bus_rdata[1:0]          = sel_q;
            end
            REG_COUNT: bus_rdata = cnt_q;
            REG_LIMIT: bus_rdata = limit_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             run_on,
    input logic             pre_tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_on,
    input logic             dma_req
);

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    // R4
    req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> flag_on);

    // R6
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_on && !(bus_en && bus_we && bus_addr == 2'd2)) |=> $stable(cnt_q));

    // R6
    stop_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_on |=> !dma_req);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 2'd0 && bus_wdata[0]) |=> run_on);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_on) |-> $past(bus_en && bus_we && bus_addr == 2'd1 && !bus_wdata[7]));

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |=> !pre_tick);

    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 2'd2) |=> (cnt_q == $past(bus_wdata)));

endmodule

bind match_timer mt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run_on    (run_on),
    .pre_tick  (pre_tick),
    .cnt_q     (cnt_q),
    .flag_on   (flag_on),
    .dma_req   (dma_req)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        dma_req;

    always #4 clk = ~clk;

    match_timer u_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dma_req   (dma_req)
    );

    typedef struct {
        string       tag;
        bit          is_req;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    pending = 0;
    int    req_seen = 0;
    bit    done = 0;

    // monitor: counts request cycles and scores queued expectations
    always @(negedge clk) begin
        if (dma_req) req_seen++;
        if (pending) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            act = it.is_req ? 16'(req_seen) : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
            pending = 0;
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_chk(input logic [1:0] a, input logic [15:0] e, input string tag);
        item_t it;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.tag = tag; it.is_req = 1'b0; it.exp = e;
        q.push_back(it);
        pending = 1;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic req_chk(input int e, input string tag);
        item_t it;
        it.tag = tag; it.is_req = 1'b1; it.exp = 16'(e);
        q.push_back(it);
        pending = 1;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..all actual=expired expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state, R10 map
        read_chk(2'd0, 16'h0000, "R1 start after reset");
        read_chk(2'd1, 16'h0000, "R1 status after reset");
        read_chk(2'd2, 16'h0000, "R1 count after reset");
        read_chk(2'd3, 16'hFFFF, "R1 R10 limit after reset");
        req_chk(0, "R1 no request after reset");

        // R2 run with divide-by-4, R3 select 00
        bus_write(2'd0, 16'h0001);
        idle(8);
        read_chk(2'd2, 16'd2, "R3 div4 count after 8 clocks");
        read_chk(2'd0, 16'h0001, "R2 start readback running");

        // R6 halt freezes the count
        bus_write(2'd0, 16'h0000);
        req_seen = 0;
        idle(20);
        read_chk(2'd2, 16'd2, "R6 count frozen while halted");
        read_chk(2'd0, 16'h0000, "R2 start readback halted");
        req_chk(0, "R6 no request while halted");

        // R7 immediate load while running
        bus_write(2'd0, 16'h0001);
        bus_write(2'd2, 16'h1234);
        read_chk(2'd2, 16'h1234, "R7 count load while running");
        bus_write(2'd0, 16'h0000);

        // R3 other divider selects
        for (int s = 1; s < 4; s++) begin
            int div;
            div = (s == 3) ? 64 : (1 << (s + 2));
            bus_write(2'd2, 16'h0000);
            bus_write(2'd1, 16'(s));
            bus_write(2'd0, 16'h0001);
            idle(3 * div);
            read_chk(2'd2, 16'd3, $sformatf("R3 select %0d count", s));
            bus_write(2'd0, 16'h0000);
            read_chk(2'd1, 16'(s), "R3 R10 select readback");
        end

        // R9 divider phase reset by halt
        bus_write(2'd1, 16'h0000);
        bus_write(2'd2, 16'h0000);
        bus_write(2'd0, 16'h0001);
        idle(2);
        bus_write(2'd0, 16'h0000);
        idle(2);
        bus_write(2'd0, 16'h0001);
        idle(3);
        read_chk(2'd2, 16'd0, "R9 no early advance after restart");
        read_chk(2'd2, 16'd1, "R9 advance after full period");
        bus_write(2'd0, 16'h0000);

        // R4 wrap and R8 pulses
        bus_write(2'd2, 16'h0000);
        bus_write(2'd3, 16'h0002);
        bus_write(2'd0, 16'h0001);
        req_seen = 0;
        idle(122);
        req_chk(10, "R8 R4 ten one-clock pulses in 120 clocks");
        read_chk(2'd2, 16'd0, "R4 count wrapped to 0");
        bus_write(2'd0, 16'h0000);

        // R5 flag clear protocol
        bus_write(2'd1, 16'h0000);
        read_chk(2'd1, 16'h0080, "R5 write 0 without read keeps flag");
        bus_write(2'd1, 16'h0080);
        read_chk(2'd1, 16'h0080, "R5 write 1 keeps flag");
        bus_write(2'd1, 16'h0000);
        read_chk(2'd1, 16'h0000, "R5 read then write 0 clears flag");

        // R6 no more pulses after halt
        req_seen = 0;
        idle(40);
        req_chk(0, "R6 no request after halt");

        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule